// File: doc/BRIEF.md
# Indirect Configuration and I/O Window Port

This block sits on a big-endian register bus and gives software indirect access to two downstream address spaces. Software first loads a base address into an address register, then reads or writes one of two data windows. A configuration-window access becomes a configuration-space request and an I/O-window access becomes an I/O-space request. The address of each request is the stored base with bits [1:0] cleared, combined with the byte offset of the access inside the window.

Every access is checked before anything is sent downstream. The size must be legal and the offset must be naturally aligned. Data crosses between the big-endian register bus and the little-endian downstream lanes in both directions. A data-window access holds the register bus until the downstream port acknowledges. The downstream error status is then returned with the response.

Top module: `ica_port`

## Requirements
- R1: After reset `rb_ack` and `dn_req` are low, and the address register reads back 0.
- R2: The address register is selected by `rb_addr[3:2]` = 0. A word write at offset 0 stores all 32 bits. A word read at offset 0 returns exactly the stored value, including bits [1:0]. Neither access issues a downstream request.
- R3: An access to the address register that is not a word access at offset 0 gets an error response. It leaves the register unchanged and issues no downstream request.
- R4: An access to the configuration window (`rb_addr[3:2]` = 1) issues one request with `dn_space` = 0. Its `dn_addr` equals the stored base with bits [1:0] replaced by `rb_addr[1:0]`. No enable bit gates the request.
- R5: An access to the I/O window (`rb_addr[3:2]` = 2) issues one request with `dn_space` = 1. It uses the same address rule as R4, and `dn_size` equals `rb_size`.
- R6: Size codes are 0 = byte, 1 = halfword, 2 = word and 3 = illegal. A word is legal only at offset 0. A halfword is legal at offsets 0 and 2. A byte is legal at any offset. An illegal size, an illegal offset or `rb_addr[3:2]` = 3 gets an error response and issues no downstream request.
- R7: Register-bus data is right-justified and big-endian, so the byte at the lowest address is the most significant byte of the access. Downstream byte address A uses lane A[1:0], which is bits [8*A+7:8*A]. `dn_be` marks exactly the lanes the access covers. On writes, unused lanes carry zero. On reads, unused upper bits of `rb_rdata` are zero.
- R8: A data-window access does not acknowledge on the register bus before `dn_ack`. The read data and `dn_err` captured with `dn_ack` are returned on `rb_rdata` and `rb_err`.
- R9: `dn_req` and its address and byte enables stay stable until `dn_ack`. `rb_ack` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rb_req | input | 1 | Register access request, held until `rb_ack` |
| rb_write | input | 1 | 1 = write, 0 = read |
| rb_addr | input | RB_AW | [3:2] selects the register or window, [1:0] is the byte offset |
| rb_size | input | 2 | Access size code |
| rb_wdata | input | 32 | Write data, right-justified, big-endian |
| rb_ack | output | 1 | One-cycle completion pulse |
| rb_err | output | 1 | Error status, valid with `rb_ack` |
| rb_rdata | output | 32 | Read data, valid with `rb_ack` |
| dn_req | output | 1 | Downstream request, held until `dn_ack` |
| dn_write | output | 1 | Downstream direction |
| dn_space | output | 1 | 0 = configuration, 1 = I/O |
| dn_addr | output | ADDR_W | Downstream byte address |
| dn_size | output | 2 | Size code of the request |
| dn_be | output | 4 | Little-endian byte-lane enables |
| dn_wdata | output | 32 | Little-endian write data |
| dn_ack | input | 1 | Downstream completion |
| dn_rdata | input | 32 | Little-endian read data, valid with `dn_ack` |
| dn_err | input | 1 | Downstream error, valid with `dn_ack` |

## Verification
A corrupted base register shows up on `dn_addr` at the next data-window request. It also shows in the readback of the address register, one cycle after the read is accepted. A wrong lane mapping shows up in `dn_wdata` or `dn_be` in the cycle the request appears, or in `rb_rdata` on the acknowledge of the read. A wrong legality decision shows up within two cycles, as a missing error or as a downstream request that should not exist. A stuck or early acknowledge breaks the stall rule before the downstream port responds.

// File: rtl/ica_pkg.sv
package ica_pkg;
   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;
   localparam logic [1:0] SZ_WORD = 2'd2;
   localparam logic [1:0] SZ_BAD  = 2'd3;

   localparam logic [1:0] SEL_BASE = 2'd0;
   localparam logic [1:0] SEL_CFG  = 2'd1;
   localparam logic [1:0] SEL_IO   = 2'd2;

   localparam logic SPACE_CFG = 1'b0;
   localparam logic SPACE_IO  = 1'b1;

   typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RESP} ica_state_e;
endpackage

// File: rtl/ica_decode.sv
module ica_decode
   import ica_pkg::*;
(
   input  logic [1:0] sel,
   input  logic [1:0] off,
   input  logic [1:0] size,
   output logic       is_base,
   output logic       is_data,
   output logic       space,
   output logic       legal
);
   logic aligned;

   always_comb begin
      unique case (size)
         SZ_BYTE: aligned = 1'b1;
         SZ_HALF: aligned = ~off[0];
         SZ_WORD: aligned = (off == 2'd0);
         default: aligned = 1'b0;
      endcase
   end

   assign is_base = (sel == SEL_BASE);
   assign is_data = (sel == SEL_CFG) || (sel == SEL_IO);
   assign space   = (sel == SEL_IO) ? SPACE_IO : SPACE_CFG;

   always_comb begin
      if (is_base)      legal = (size == SZ_WORD) && (off == 2'd0);
      else if (is_data) legal = aligned;
      else              legal = 1'b0;
   end
endmodule

// File: rtl/ica_lanes.sv
module ica_lanes #(
   parameter int DW = 32
) (
   input  logic [1:0]      size,
   input  logic [1:0]      off,
   input  logic [DW-1:0]   bus_wdata,
   input  logic [DW-1:0]   dn_rdata,
   output logic [DW-1:0]   dn_wdata,
   output logic [DW/8-1:0] dn_be,
   output logic [DW-1:0]   bus_rdata
);
   localparam int NB = DW / 8;

   logic [3:0] nbytes;
   assign nbytes = 4'd1 << size;

   for (genvar l = 0; l < NB; l++) begin : g_lane
      logic [7:0] wbyte;
      logic       en;
      logic [7:0] rbyte;
      always_comb begin
         int rel;
         int src;
         rel   = l - int'(off);
         src   = int'(nbytes) - 1 - rel;
         en    = 1'b0;
         wbyte = 8'h00;
         if (rel >= 0 && rel < int'(nbytes) && src < NB) begin
            en    = 1'b1;
            wbyte = bus_wdata[8*src +: 8];
         end
      end
      always_comb begin
         int lane;
         lane  = int'(off) + int'(nbytes) - 1 - l;
         rbyte = 8'h00;
         if (l < int'(nbytes) && lane >= 0 && lane < NB)
            rbyte = dn_rdata[8*lane +: 8];
      end
      assign dn_wdata[8*l +: 8]  = wbyte;
      assign dn_be[l]            = en;
      assign bus_rdata[8*l +: 8] = rbyte;
   end
endmodule

// File: rtl/ica_port.sv
module ica_port
   import ica_pkg::*;
#(
   parameter int          ADDR_W   = 32,
   parameter int          RB_AW    = 4,
   parameter logic [31:0] BASE_RST = 32'h0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rb_req,
   input  logic              rb_write,
   input  logic [RB_AW-1:0]  rb_addr,
   input  logic [1:0]        rb_size,
   input  logic [31:0]       rb_wdata,
   output logic              rb_ack,
   output logic              rb_err,
   output logic [31:0]       rb_rdata,
   output logic              dn_req,
   output logic              dn_write,
   output logic              dn_space,
   output logic [ADDR_W-1:0] dn_addr,
   output logic [1:0]        dn_size,
   output logic [3:0]        dn_be,
   output logic [31:0]       dn_wdata,
   input  logic              dn_ack,
   input  logic [31:0]       dn_rdata,
   input  logic              dn_err
);
   localparam int DW = 32;
   localparam int NB = DW / 8;

   if (ADDR_W < 3 || ADDR_W > DW) begin : g_bad_addr_w
      $error("ica_port: ADDR_W must lie in 3..32");
   end
   if (RB_AW != 4) begin : g_bad_rb_aw
      $error("ica_port: RB_AW must be 4");
   end

   ica_state_e        state_q;
   logic [ADDR_W-1:0] base_q;
   logic [31:0]       rdata_q;
   logic              err_q;

   logic              is_base, is_data, space_w, legal;
   logic [1:0]        ln_size, ln_off;
   logic [DW-1:0]     ln_wdata, ln_rdata;
   logic [NB-1:0]     ln_be;

   ica_decode u_dec (
      .sel     (rb_addr[3:2]),
      .off     (rb_addr[1:0]),
      .size    (rb_size),
      .is_base (is_base),
      .is_data (is_data),
      .space   (space_w),
      .legal   (legal)
   );

   assign ln_size = (state_q == ST_IDLE) ? rb_size      : dn_size;
   assign ln_off  = (state_q == ST_IDLE) ? rb_addr[1:0] : dn_addr[1:0];

   ica_lanes #(.DW(DW)) u_lanes (
      .size      (ln_size),
      .off       (ln_off),
      .bus_wdata (rb_wdata),
      .dn_rdata  (dn_rdata),
      .dn_wdata  (ln_wdata),
      .dn_be     (ln_be),
      .bus_rdata (ln_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         base_q   <= BASE_RST[ADDR_W-1:0];
         rdata_q  <= '0;
         err_q    <= 1'b0;
         dn_req   <= 1'b0;
         dn_write <= 1'b0;
         dn_space <= SPACE_CFG;
         dn_addr  <= '0;
         dn_size  <= SZ_BYTE;
         dn_be    <= '0;
         dn_wdata <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (rb_req) begin
               if (!legal) begin
                  err_q   <= 1'b1;
                  rdata_q <= '0;
                  state_q <= ST_RESP;
               end else if (is_base) begin
                  if (rb_write) base_q <= rb_wdata[ADDR_W-1:0];
                  rdata_q <= rb_write ? 32'h0 : 32'(base_q);
                  err_q   <= 1'b0;
                  state_q <= ST_RESP;
               end else if (is_data) begin
                  dn_req   <= 1'b1;
                  dn_write <= rb_write;
                  dn_space <= space_w;
                  dn_addr  <= {base_q[ADDR_W-1:2], rb_addr[1:0]};
                  dn_size  <= rb_size;
                  dn_be    <= ln_be;
                  dn_wdata <= rb_write ? ln_wdata : '0;
                  state_q  <= ST_WAIT;
               end
            end
            ST_WAIT: if (dn_ack) begin
               dn_req  <= 1'b0;
               err_q   <= dn_err;
               rdata_q <= dn_write ? 32'h0 : ln_rdata;
               state_q <= ST_RESP;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign rb_ack   = (state_q == ST_RESP);
   assign rb_err   = err_q;
   assign rb_rdata = rdata_q;
endmodule

// File: rtl/ica_port_chk.sv
module ica_port_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rb_ack,
   input logic              dn_req,
   input logic              dn_ack,
   input logic [ADDR_W-1:0] dn_addr,
   input logic [1:0]        dn_size,
   input logic [3:0]        dn_be,
   input logic [ADDR_W-1:0] base_q
);
   // R4 / R5: the request address keeps the upper bits of the stored base
   a_r4_base_bits: assert property (@(posedge clk) disable iff (!rst_n)
      dn_req |-> dn_addr[ADDR_W-1:2] == base_q[ADDR_W-1:2]);

   // R6: no misaligned or illegal-size request ever reaches downstream
   a_r6_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      dn_req |-> (dn_size != 2'd3) && (dn_size != 2'd2 || dn_addr[1:0] == 2'd0)
                 && (dn_size != 2'd1 || !dn_addr[0]));

   // R7: lane enables cover exactly the access size
   a_r7_be_count: assert property (@(posedge clk) disable iff (!rst_n)
      dn_req |-> $countones(dn_be) == (1 << dn_size));

   // R8: the register bus is held while downstream is outstanding
   a_r8_stall: assert property (@(posedge clk) disable iff (!rst_n)
      dn_req |-> !rb_ack);

   // R9: request held stable until acknowledged
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      dn_req && !dn_ack |=> dn_req && $stable(dn_addr) && $stable(dn_be));

   // R9: acknowledge is a single-cycle pulse
   a_r9_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rb_ack |=> !rb_ack);
endmodule

bind ica_port ica_port_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .rb_ack  (rb_ack),
   .dn_req  (dn_req),
   .dn_ack  (dn_ack),
   .dn_addr (dn_addr),
   .dn_size (dn_size),
   .dn_be   (dn_be),
   .base_q  (base_q)
);

// File: tb/tb_ica_port.sv
module tb_ica_port;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rb_req = 1'b0, rb_write = 1'b0;
   logic [3:0]  rb_addr = '0;
   logic [1:0]  rb_size = '0;
   logic [31:0] rb_wdata = '0;
   logic        rb_ack, rb_err;
   logic [31:0] rb_rdata;
   logic        dn_req, dn_write, dn_space;
   logic [31:0] dn_addr;
   logic [1:0]  dn_size;
   logic [3:0]  dn_be;
   logic [31:0] dn_wdata;
   logic        dn_ack = 1'b0;
   logic [31:0] dn_rdata = '0;
   logic        dn_err = 1'b0;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   // captured outcome of the last access
   logic [31:0] got_rd, cap_addr, cap_wd;
   logic        got_err, seen, cap_space, cap_wr;
   logic [1:0]  cap_size;
   logic [3:0]  cap_be;
   logic [31:0] base_model = 32'h0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ica_port dut (.*);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Expected little-endian lane image of a big-endian right-justified value
   function automatic logic [31:0] lanes_of(int off, int n, logic [31:0] v);
      logic [7:0] mem [4];
      logic [31:0] r = 0;
      for (int k = 0; k < 4; k++) mem[k] = 8'h00;
      for (int k = 0; k < n; k++) mem[off+k] = 8'((v >> (8*(n-1-k))) & 32'hFF);
      for (int k = 0; k < 4; k++) r[8*k +: 8] = mem[k];
      return r;
   endfunction

   function automatic logic [3:0] be_of(int off, int n);
      logic [3:0] m = 0;
      for (int k = 0; k < n; k++) m[off+k] = 1'b1;
      return m;
   endfunction

   function automatic logic [31:0] value_of(int off, int n, logic [31:0] lanes);
      logic [31:0] v = 0;
      for (int k = 0; k < n; k++) v = (v << 8) | 32'(lanes[8*(off+k) +: 8]);
      return v;
   endfunction

   task automatic access(input logic [1:0] sel, input logic [1:0] off, input logic [1:0] sz,
                         input logic wr, input logic [31:0] wd, input logic [31:0] ret,
                         input logic ret_err, input int delay);
      bit acked = 0;
      int cnt = 0;
      int guard = 0;
      seen = 0;
      rb_req = 1; rb_write = wr; rb_addr = {sel, off}; rb_size = sz; rb_wdata = wd;
      forever begin
         @(negedge clk);
         dn_ack = 0;
         guard++;
         if (rb_ack) begin
            got_rd = rb_rdata; got_err = rb_err;
            if (seen && !acked) chk("R8 early acknowledge", 32'd1, 32'd0);
            break;
         end
         if (guard > 200) begin
            chk("R9 no acknowledge", 32'd0, 32'd1);
            break;
         end
         if (dn_req && !seen) begin
            seen = 1; cap_addr = dn_addr; cap_wd = dn_wdata; cap_space = dn_space;
            cap_size = dn_size; cap_be = dn_be; cap_wr = dn_write;
         end
         if (seen && !acked) begin
            if (cnt == delay) begin
               dn_ack = 1; dn_rdata = ret; dn_err = ret_err; acked = 1;
            end
            cnt++;
         end
      end
      rb_req = 0;
   endtask

   // data-window access with full comparison against the model
   task automatic data_access(input string tag, input logic [1:0] sel, input int off, input int n,
                              input logic wr, input logic [31:0] wd, input logic [31:0] ret,
                              input logic ret_err, input int delay);
      logic [1:0] sz = (n == 1) ? 2'd0 : (n == 2) ? 2'd1 : 2'd2;
      access(sel, 2'(off), sz, wr, wd, ret, ret_err, delay);
      chk({tag, " request issued"}, 32'(seen), 32'd1);
      chk({tag, " R4 address"}, cap_addr, {base_model[31:2], 2'(off)});
      chk({tag, " R5 space"}, 32'(cap_space), (sel == 2'd2) ? 32'd1 : 32'd0);
      chk({tag, " R5 size"}, 32'(cap_size), 32'(sz));
      chk({tag, " R7 byte enables"}, 32'(cap_be), 32'(be_of(off, n)));
      chk({tag, " direction"}, 32'(cap_wr), 32'(wr));
      if (wr) chk({tag, " R7 write lanes"}, cap_wd, lanes_of(off, n, wd));
      else    chk({tag, " R7/R8 read data"}, got_rd, value_of(off, n, ret));
      chk({tag, " R8 error status"}, 32'(got_err), 32'(ret_err));
   endtask

   task automatic illegal(input string tag, input logic [1:0] sel, input logic [1:0] off,
                          input logic [1:0] sz, input logic wr);
      access(sel, off, sz, wr, 32'hDEAD_BEEF, 32'h0, 1'b0, 0);
      chk({tag, " error"}, 32'(got_err), 32'd1);
      chk({tag, " no request"}, 32'(seen), 32'd0);
   endtask

   task automatic base_read(input string tag);
      access(2'd0, 2'd0, 2'd2, 1'b0, 32'h0, 32'h0, 1'b0, 0);
      chk({tag, " readback"}, got_rd, base_model);
      chk({tag, " readback error"}, 32'(got_err), 32'd0);
      chk({tag, " no request"}, 32'(seen), 32'd0);
   endtask

   task automatic base_write(input string tag, input logic [31:0] v);
      access(2'd0, 2'd0, 2'd2, 1'b1, v, 32'h0, 1'b0, 0);
      base_model = v;
      chk({tag, " write error"}, 32'(got_err), 32'd0);
      chk({tag, " no request"}, 32'(seen), 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 ack low in reset", 32'(rb_ack), 32'd0);
      rst_n = 1;
      @(negedge clk);
      chk("R1 ack low after reset", 32'(rb_ack), 32'd0);
      chk("R1 request low after reset", 32'(dn_req), 32'd0);
      base_read("R1 reset value");

      base_write("R2", 32'h1234_5677);
      base_read("R2");

      illegal("R3 halfword", 2'd0, 2'd0, 2'd1, 1'b1);
      illegal("R3 offset", 2'd0, 2'd2, 2'd2, 1'b1);
      base_read("R3 unchanged");

      data_access("R4 cfg word write", 2'd1, 0, 4, 1'b1, 32'hAABB_CCDD, 32'h0, 1'b0, 0);
      data_access("R4 cfg byte read", 2'd1, 3, 1, 1'b0, 32'h0, 32'h1122_3344, 1'b0, 2);
      data_access("R5 io half write", 2'd2, 2, 2, 1'b1, 32'h0000_BEEF, 32'h0, 1'b0, 1);
      data_access("R5 io half read", 2'd2, 2, 2, 1'b0, 32'h0, 32'h5566_7788, 1'b0, 0);
      data_access("R7 io word read", 2'd2, 0, 4, 1'b0, 32'h0, 32'h0102_0304, 1'b0, 3);
      data_access("R7 io byte write", 2'd2, 1, 1, 1'b1, 32'h0000_005A, 32'h0, 1'b0, 0);

      illegal("R6 word off1", 2'd2, 2'd1, 2'd2, 1'b0);
      illegal("R6 half off1", 2'd2, 2'd1, 2'd1, 1'b1);
      illegal("R6 half off3", 2'd1, 2'd3, 2'd1, 1'b0);
      illegal("R6 size3", 2'd2, 2'd0, 2'd3, 1'b1);
      illegal("R6 unmapped", 2'd3, 2'd0, 2'd2, 1'b0);

      data_access("R8 error read", 2'd1, 0, 4, 1'b0, 32'h0, 32'hCAFE_F00D, 1'b1, 6);
      data_access("R8 error write", 2'd2, 0, 2, 1'b1, 32'h0000_1357, 32'h0, 1'b1, 4);

      base_write("R2 second", 32'hFFFF_FFFE);
      base_read("R2 second");
      data_access("R9 cfg half at top", 2'd1, 2, 2, 1'b0, 32'h0, 32'hA1B2_C3D4, 1'b0, 5);

      @(negedge clk);
      chk("R9 ack single pulse", 32'(rb_ack), 32'd0);
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule